// File: doc/BRIEF.md
# DAC Trigger and Data-Hold Front End

This block is the digital side of a two-channel 12-bit digital-to-analog converter. Software writes sample values over a byte-wide register port. Each channel accepts three formats: 12 bits right-justified, 12 bits left-justified, or 8 bits right-justified. A dual form loads both channels from one write sequence. The value first lands in a per-channel holding register. It then moves to the channel's 12-bit output code, which feeds the converter; the analog level is the output code over 4095.

A channel either copies the held value straight through, or waits for a trigger that its configuration selects. The trigger can come from the external pin, from timer A, from timer B, or from a self-clearing software bit. A hardware trigger can also raise a DMA request, which stays up until it is acknowledged. A second hardware trigger that arrives while the request is still unacknowledged sets an underrun flag, and that flag can drive an interrupt.

Register map (5-bit address, byte data):
- 0x00 / 0x01: channel 0 / 1 configuration. Bit 0 enables the channel, bit 1 enables triggering, bits 3:2 select the trigger source (0 pin, 1 timer A, 2 timer B, 3 software), bit 4 enables DMA requests, bit 5 enables the underrun interrupt.
- 0x02: software trigger. Bit n fires channel n.
- 0x03: underrun status clear. Writing 0 to bit n clears channel n's flag.
- 0x04–0x08 for channel 0 and 0x09–0x0D for channel 1, at offsets from the channel base:
  - +0 right-justified high byte, +1 right-justified low byte;
  - +2 left-justified high byte, +3 left-justified low byte;
  - +4 8-bit value.
- Dual 12-bit right-justified: 0x10 ch0 high, 0x11 ch0 low, 0x12 ch1 high, 0x13 ch1 low.
- Dual 12-bit left-justified: 0x14–0x17, in the same byte order.
- Dual 8-bit: 0x18 ch0, 0x19 ch1.

Top module: `dac_trigger_frontend`

## Requirements
- R1: After a synchronous reset, both output codes are 0, and no DMA request, underrun flag or interrupt is asserted.
- R2: A right-justified 12-bit write loads the holding register with {high[3:0], low} when the low byte is written. For an enabled channel with triggering off, the output code takes that value one clock later.
- R3: A left-justified write loads {high, low}[15:4]. An 8-bit write loads {byte, 4'b0000}.
- R4: Writing only a high byte never changes the holding register or the output code.
- R5: A dual write loads both channels' holding registers on the same clock, and only when the final byte (0x13, 0x17 or 0x19) is written. Earlier bytes of the sequence change neither output.
- R6: With triggering on, the output code holds until a rising edge on the selected source (source code 0 pin, 1 timer A, 2 timer B). Edges on sources that are not selected are ignored. The transfer lands on the clock that samples the edge.
- R7: Writing 1 to bit n of 0x02 sets channel n's software trigger; a single write can set both bits. A channel with source code 3 transfers on the next clock. The bit then clears itself, so later holding-register writes are not transferred.
- R8: While a channel is enabled, writes to its trigger-enable and source fields are ignored.
- R9: A hardware trigger on a channel with DMA enabled raises its DMA request, which stays high until the acknowledge. A software trigger never raises it.
- R10: A hardware trigger with DMA enabled, while the request is high and not being acknowledged, sets the underrun flag. Writing 0 to its bit in 0x03 clears the flag; writing 1 leaves it unchanged.
- R11: The interrupt is high whenever some channel has both its underrun flag and its interrupt enable set.
- R12: A disabled channel never changes its output code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Register write data |
| ext_trig | input | 1 | External pin trigger, rising-edge sensitive |
| tmr_a_trig | input | 1 | Timer A trigger, rising-edge sensitive |
| tmr_b_trig | input | 1 | Timer B trigger, rising-edge sensitive |
| dma_ack | input | 2 | Per-channel DMA acknowledge |
| code0 | output | 12 | Channel 0 output code |
| code1 | output | 12 | Channel 1 output code |
| dma_req | output | 2 | Per-channel DMA request |
| udr_flag | output | 2 | Per-channel underrun flag |
| irq | output | 1 | Underrun interrupt |

## Verification
The assertions assume that the trigger inputs and the acknowledges are synchronous to clk. They also assume that an acknowledge has an effect only on a channel whose request is pending. The bench respects both: it changes every input on the falling edge, and it writes only to mapped addresses. In the random phase it may acknowledge with no request pending; the request is then already low, so the acknowledge has no effect. It also leaves at least one low cycle between directed trigger pulses, so each pulse makes exactly one rising edge.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int DW  = 12;
  localparam int BW  = 8;
  localparam int NCH = 2;

  // register addresses
  localparam int A_CFG    = 0;
  localparam int A_SWT    = 2;
  localparam int A_STAT   = 3;
  localparam int A_SGL    = 4;
  localparam int SGL_SPAN = 5;
  localparam int A_DUAL_R = 16;
  localparam int A_DUAL_L = 20;
  localparam int A_DUAL_8 = 24;

  typedef enum logic [1:0] {
    SRC_PIN   = 2'd0,
    SRC_TMR_A = 2'd1,
    SRC_TMR_B = 2'd2,
    SRC_SOFT  = 2'd3
  } trig_src_e;

  typedef struct packed {
    logic      irq_en;
    logic      dma_en;
    trig_src_e src;
    logic      trig_en;
    logic      chan_en;
  } chan_cfg_t;

  function automatic logic [DW-1:0] pack_right(input logic [BW-1:0] hi,
                                               input logic [BW-1:0] lo);
    logic [2*BW-1:0] w;
    w = {hi, lo};
    return w[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] pack_left(input logic [BW-1:0] hi,
                                              input logic [BW-1:0] lo);
    logic [2*BW-1:0] w;
    w = {hi, lo};
    return w[2*BW-1 -: DW];
  endfunction

  function automatic logic [DW-1:0] pack_byte(input logic [BW-1:0] b);
    return {b, {(DW-BW){1'b0}}};
  endfunction
endpackage

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BW-1:0]            wdata,
  output chan_cfg_t [NCH-1:0]      cfg,
  output logic [NCH-1:0][DW-1:0]   dhr,
  output logic [NCH-1:0]           sw_bit,
  output logic [NCH-1:0]           udr_clr
);
  logic [NCH-1:0][BW-1:0] hi_stage;
  logic [BW-1:0]          lo_stage;

  function automatic logic at(input int a);
    return wr_en && (addr == ADDR_W'(a));
  endfunction

  always_comb begin
    for (int i = 0; i < NCH; i++) udr_clr[i] = at(A_STAT) && !wdata[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      dhr      <= '0;
      sw_bit   <= '0;
      hi_stage <= '0;
      lo_stage <= '0;
    end else begin
      sw_bit <= at(A_SWT) ? wdata[NCH-1:0] : '0;
      for (int i = 0; i < NCH; i++) begin
        if (at(A_CFG + i)) begin
          cfg[i].chan_en <= wdata[0];
          cfg[i].dma_en  <= wdata[4];
          cfg[i].irq_en  <= wdata[5];
          if (!cfg[i].chan_en) begin
            cfg[i].trig_en <= wdata[1];
            cfg[i].src     <= trig_src_e'(wdata[3:2]);
          end
        end
        if (at(A_SGL + i*SGL_SPAN) || at(A_SGL + i*SGL_SPAN + 2))
          hi_stage[i] <= wdata;
        if (at(A_SGL + i*SGL_SPAN + 1)) dhr[i] <= pack_right(hi_stage[i], wdata);
        if (at(A_SGL + i*SGL_SPAN + 3)) dhr[i] <= pack_left(hi_stage[i], wdata);
        if (at(A_SGL + i*SGL_SPAN + 4)) dhr[i] <= pack_byte(wdata);
      end
      // dual sequences: ch0 high, ch0 low, ch1 high, ch1 low
      if (at(A_DUAL_R) || at(A_DUAL_L))         hi_stage[0] <= wdata;
      if (at(A_DUAL_R + 1) || at(A_DUAL_L + 1)) lo_stage    <= wdata;
      if (at(A_DUAL_R + 2) || at(A_DUAL_L + 2)) hi_stage[1] <= wdata;
      if (at(A_DUAL_R + 3)) begin
        dhr[0] <= pack_right(hi_stage[0], lo_stage);
        dhr[1] <= pack_right(hi_stage[1], wdata);
      end
      if (at(A_DUAL_L + 3)) begin
        dhr[0] <= pack_left(hi_stage[0], lo_stage);
        dhr[1] <= pack_left(hi_stage[1], wdata);
      end
      if (at(A_DUAL_8)) lo_stage <= wdata;
      if (at(A_DUAL_8 + 1)) begin
        dhr[0] <= pack_byte(lo_stage);
        dhr[1] <= pack_byte(wdata);
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // software trigger bit lives for one clock unless rewritten
    assert_sw_selfclear_R7: assert property (@(posedge clk) disable iff (rst)
      (sw_bit[g] && !(at(A_SWT) && wdata[g])) |=> !sw_bit[g]);
    // trigger fields frozen while the channel runs
    assert_src_locked_R8: assert property (@(posedge clk) disable iff (rst)
      cfg[g].chan_en |=> ($stable(cfg[g].src) && $stable(cfg[g].trig_en)));
  end
endmodule

// File: rtl/dacfe_chan.sv
module dacfe_chan
  import dacfe_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  chan_cfg_t     cfg,
  input  logic [DW-1:0] dhr,
  input  logic          sw_bit,
  input  logic          pin_evt,
  input  logic          ta_evt,
  input  logic          tb_evt,
  input  logic          dma_ack,
  input  logic          udr_clr,
  output logic [DW-1:0] dor,
  output logic          dma_req,
  output logic          udr
);
  logic armed, sel_evt, hw_hit, sw_hit, udr_set;

  assign armed = cfg.chan_en && cfg.trig_en;

  always_comb begin
    unique case (cfg.src)
      SRC_PIN:   sel_evt = pin_evt;
      SRC_TMR_A: sel_evt = ta_evt;
      SRC_TMR_B: sel_evt = tb_evt;
      default:   sel_evt = 1'b0;
    endcase
  end

  assign hw_hit  = armed && (cfg.src != SRC_SOFT) && sel_evt;
  assign sw_hit  = armed && (cfg.src == SRC_SOFT) && sw_bit;
  assign udr_set = hw_hit && cfg.dma_en && dma_req && !dma_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      dor     <= '0;
      dma_req <= 1'b0;
      udr     <= 1'b0;
    end else begin
      if (cfg.chan_en && (!cfg.trig_en || hw_hit || sw_hit)) dor <= dhr;
      if (hw_hit && cfg.dma_en) dma_req <= 1'b1;
      else if (dma_ack)         dma_req <= 1'b0;
      udr <= (udr && !udr_clr) || udr_set;
    end
  end

  assert_req_from_hw_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_req) |-> $past(hw_hit && cfg.dma_en));
  assert_udr_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(udr) |-> $past(dma_req && !dma_ack && hw_hit));
  assert_hold_untriggered_R6: assert property (@(posedge clk) disable iff (rst)
    (armed && !hw_hit && !sw_hit) |=> $stable(dor));
  assert_disabled_frozen_R12: assert property (@(posedge clk) disable iff (rst)
    !cfg.chan_en |=> $stable(dor));
endmodule

// File: rtl/dac_trigger_frontend.sv
module dac_trigger_frontend
  import dacfe_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BW-1:0]     reg_wdata,
  input  logic              ext_trig,
  input  logic              tmr_a_trig,
  input  logic              tmr_b_trig,
  input  logic [NCH-1:0]    dma_ack,
  output logic [DW-1:0]     code0,
  output logic [DW-1:0]     code1,
  output logic [NCH-1:0]    dma_req,
  output logic [NCH-1:0]    udr_flag,
  output logic              irq
);
  chan_cfg_t [NCH-1:0]    cfg;
  logic [NCH-1:0][DW-1:0] dhr, dor;
  logic [NCH-1:0]         sw_bit, udr_clr, ie;
  logic                   pin_q, ta_q, tb_q;
  logic                   pin_evt, ta_evt, tb_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      ta_q  <= 1'b0;
      tb_q  <= 1'b0;
    end else begin
      pin_q <= ext_trig;
      ta_q  <= tmr_a_trig;
      tb_q  <= tmr_b_trig;
    end
  end

  assign pin_evt = ext_trig   && !pin_q;
  assign ta_evt  = tmr_a_trig && !ta_q;
  assign tb_evt  = tmr_b_trig && !tb_q;

  dacfe_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cfg(cfg), .dhr(dhr), .sw_bit(sw_bit), .udr_clr(udr_clr)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dacfe_chan u_chan (
      .clk(clk), .rst(rst), .cfg(cfg[g]), .dhr(dhr[g]), .sw_bit(sw_bit[g]),
      .pin_evt(pin_evt), .ta_evt(ta_evt), .tb_evt(tb_evt),
      .dma_ack(dma_ack[g]), .udr_clr(udr_clr[g]),
      .dor(dor[g]), .dma_req(dma_req[g]), .udr(udr_flag[g])
    );
    assign ie[g] = cfg[g].irq_en;
  end

  assign code0 = dor[0];
  assign code1 = dor[1];
  assign irq   = |(udr_flag & ie);
endmodule

// File: tb/dac_trigger_frontend_bench.sv
module dac_trigger_frontend_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       ext_trig = 1'b0, tmr_a_trig = 1'b0, tmr_b_trig = 1'b0;
  logic [1:0] dma_ack = '0;
  logic [11:0] code0, code1;
  logic [1:0] dma_req, udr_flag;
  logic       irq;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dac_trigger_frontend u_dac_trigger_frontend (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ext_trig(ext_trig), .tmr_a_trig(tmr_a_trig), .tmr_b_trig(tmr_b_trig),
    .dma_ack(dma_ack), .code0(code0), .code1(code1), .dma_req(dma_req),
    .udr_flag(udr_flag), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_en[2], m_ten[2], m_src[2], m_dma[2], m_ie[2], m_sw[2];
  int m_hi[2], m_lo, m_dhr[2], m_dor[2], m_req[2], m_udr[2];
  int p_ext, p_ta, p_tb;

  function automatic int fr(int h, int l); return ((h & 15) << 8) | l; endfunction
  function automatic int fl(int h, int l); return ((h << 8) | l) >> 4; endfunction
  function automatic int f8(int b);        return b << 4;              endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_en[c] = 0; m_ten[c] = 0; m_src[c] = 0; m_dma[c] = 0; m_ie[c] = 0; m_sw[c] = 0;
        m_hi[c] = 0; m_dhr[c] = 0; m_dor[c] = 0; m_req[c] = 0; m_udr[c] = 0;
      end
      m_lo = 0; p_ext = 0; p_ta = 0; p_tb = 0;
    end else begin
      int a, w, ev[3];
      a = int'(reg_addr); w = int'(reg_wdata);
      ev[0] = (ext_trig && !p_ext) ? 1 : 0;
      ev[1] = (tmr_a_trig && !p_ta) ? 1 : 0;
      ev[2] = (tmr_b_trig && !p_tb) ? 1 : 0;
      for (int c = 0; c < 2; c++) begin
        int hit, hw;
        hit = (m_src[c] == 3) ? m_sw[c] : ev[m_src[c]];
        if (m_en[c] != 0 && (m_ten[c] == 0 || hit != 0)) m_dor[c] = m_dhr[c];
        hw = (m_en[c] != 0 && m_ten[c] != 0 && m_src[c] != 3 && hit != 0) ? 1 : 0;
        if (reg_wr && a == 3 && ((w >> c) & 1) == 0) m_udr[c] = 0;
        if (hw != 0 && m_dma[c] != 0) begin
          if (m_req[c] != 0 && !dma_ack[c]) m_udr[c] = 1; else m_req[c] = 1;
        end else if (dma_ack[c]) m_req[c] = 0;
        m_sw[c] = (reg_wr && a == 2) ? ((w >> c) & 1) : 0;
        if (reg_wr && a == c) begin
          if (m_en[c] == 0) begin m_ten[c] = (w >> 1) & 1; m_src[c] = (w >> 2) & 3; end
          m_en[c] = w & 1; m_dma[c] = (w >> 4) & 1; m_ie[c] = (w >> 5) & 1;
        end
        if (reg_wr && (a == 4 + 5*c || a == 6 + 5*c)) m_hi[c] = w;
        if (reg_wr && a == 5 + 5*c) m_dhr[c] = fr(m_hi[c], w);
        if (reg_wr && a == 7 + 5*c) m_dhr[c] = fl(m_hi[c], w);
        if (reg_wr && a == 8 + 5*c) m_dhr[c] = f8(w);
      end
      if (reg_wr) begin
        case (a)
          16, 20: m_hi[0] = w;
          17, 21, 24: m_lo = w;
          18, 22: m_hi[1] = w;
          19: begin m_dhr[0] = fr(m_hi[0], m_lo); m_dhr[1] = fr(m_hi[1], w); end
          23: begin m_dhr[0] = fl(m_hi[0], m_lo); m_dhr[1] = fl(m_hi[1], w); end
          25: begin m_dhr[0] = f8(m_lo); m_dhr[1] = f8(w); end
          default: ;
        endcase
      end
      p_ext = ext_trig; p_ta = tmr_a_trig; p_tb = tmr_b_trig;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R6 code0 vs model", int'(code0), m_dor[0]);
      chk("R6 code1 vs model", int'(code1), m_dor[1]);
      chk("R9 dma_req vs model", int'(dma_req), m_req[1]*2 + m_req[0]);
      chk("R10 udr vs model", int'(udr_flag), m_udr[1]*2 + m_udr[0]);
      chk("R11 irq vs model", int'(irq),
          ((m_udr[0] & m_ie[0]) | (m_udr[1] & m_ie[1])));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog R1 actual=%0d expected=finish", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int a, input int d);
    reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: ext_trig = 1'b1;
      1: tmr_a_trig = 1'b1;
      default: tmr_b_trig = 1'b1;
    endcase
    @(negedge clk);
    ext_trig = 1'b0; tmr_a_trig = 1'b0; tmr_b_trig = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    idle(4);
    chk("R1 code0 reset", int'(code0), 0);
    chk("R1 code1 reset", int'(code1), 0);
    chk("R1 req/udr/irq reset", int'({dma_req, udr_flag, irq}), 0);
    rst = 1'b0;

    wr(0, 8'h01); wr(1, 8'h01);
    wr(4, 8'h0A); idle(2);
    chk("R4 high byte alone", int'(code0), 0);
    wr(5, 8'hBC); idle(1);
    chk("R2 right-justified", int'(code0), 'hABC);
    wr(11, 8'h12); wr(12, 8'h34); idle(1);
    chk("R3 left-justified", int'(code1), 'h123);
    wr(8, 8'h5A); idle(1);
    chk("R3 eight-bit", int'(code0), 'h5A0);

    wr(16, 8'h03); wr(17, 8'h21); wr(18, 8'h0F); idle(1);
    chk("R5 dual partial ch0", int'(code0), 'h5A0);
    chk("R5 dual partial ch1", int'(code1), 'h123);
    wr(19, 8'hED); idle(1);
    chk("R5 dual right ch0", int'(code0), 'h321);
    chk("R5 dual right ch1", int'(code1), 'hFED);
    wr(24, 8'h11); wr(25, 8'h22); idle(1);
    chk("R5 dual byte ch0", int'(code0), 'h110);
    chk("R5 dual byte ch1", int'(code1), 'h220);
    wr(20, 8'hAB); wr(21, 8'hC0); wr(22, 8'h98); wr(23, 8'h70); idle(1);
    chk("R5 dual left ch0", int'(code0), 'hABC);
    chk("R5 dual left ch1", int'(code1), 'h987);

    wr(0, 8'h00); wr(8, 8'h77); idle(2);
    chk("R12 disabled holds", int'(code0), 'hABC);
    wr(0, 8'h13); idle(2);
    chk("R6 armed holds", int'(code0), 'hABC);
    pulse(1);
    chk("R6 other source ignored", int'(code0), 'hABC);
    pulse(0);
    chk("R6 pin transfer", int'(code0), 'h770);
    chk("R9 request raised", int'(dma_req[0]), 1);

    pulse(0);
    chk("R10 underrun set", int'(udr_flag[0]), 1);
    chk("R11 irq masked", int'(irq), 0);
    wr(0, 8'h33);
    chk("R11 irq enabled", int'(irq), 1);
    dma_ack = 2'b01; @(negedge clk); dma_ack = 2'b00;
    chk("R9 ack drops request", int'(dma_req[0]), 0);
    wr(3, 8'h02);
    chk("R10 flag cleared", int'(udr_flag), 0);
    chk("R11 irq cleared", int'(irq), 0);

    wr(0, 8'h09); wr(8, 8'h44); idle(2);
    chk("R8 locked still armed", int'(code0), 'h770);
    pulse(2);
    chk("R8 timer B still ignored", int'(code0), 'h770);
    pulse(0);
    chk("R8 pin still selected", int'(code0), 'h440);
    chk("R9 no request with DMA off", int'(dma_req[0]), 0);

    wr(1, 8'h00); wr(1, 8'h1F); wr(13, 8'h99); idle(2);
    chk("R7 waits for software", int'(code1), 'h987);
    wr(2, 8'h03); idle(1);
    chk("R7 software transfer", int'(code1), 'h990);
    chk("R7 pin channel unaffected", int'(code0), 'h440);
    chk("R9 software makes no request", int'(dma_req[1]), 0);
    wr(13, 8'h55); idle(3);
    chk("R7 bit self-cleared", int'(code1), 'h990);

    wr(1, 8'h00); wr(1, 8'h17);
    pulse(1);
    chk("R6 timer A transfer", int'(code1), 'h550);
    chk("R9 timer request", int'(dma_req[1]), 1);
    dma_ack = 2'b10; tmr_a_trig = 1'b1; @(negedge clk);
    dma_ack = 2'b00; tmr_a_trig = 1'b0; idle(1);
    chk("R10 ack same clock no underrun", int'(udr_flag[1]), 0);
    chk("R9 request kept", int'(dma_req[1]), 1);
    dma_ack = 2'b10; @(negedge clk); dma_ack = 2'b00;
    chk("R9 request cleared", int'(dma_req[1]), 0);

    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom % 24);
      reg_wr     = ($urandom % 4) == 0;
      reg_addr   = 5'((r < 14) ? r : 16 + (r - 14));
      reg_wdata  = 8'($urandom);
      ext_trig   = ($urandom % 6) == 0;
      tmr_a_trig = ($urandom % 6) == 0;
      tmr_b_trig = ($urandom % 6) == 0;
      dma_ack    = 2'($urandom % 4 == 0 ? $urandom : 0);
      @(negedge clk);
    end
    reg_wr = 1'b0; ext_trig = 1'b0; tmr_a_trig = 1'b0; tmr_b_trig = 1'b0; dma_ack = '0;
    idle(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule